// File: doc/BRIEF.md
# CRC-32 Word Checksum Engine

This block accumulates a 32-bit cyclic redundancy check over a stream of 32-bit words. It uses the generator polynomial 0x04C11DB7 and a seed of 0xFFFFFFFF. Each word is folded in whole, most significant bit first. No bit reflection is applied to the input or to the result, and the result is not inverted at the end. Software writes words into a data register, one per clock at most, over a valid/ready write path. It reads the running checksum back from the same register. Any byte reordering a protocol needs is done by software before a word is written.

A control register holds a clear bit. Writing it reloads the seed so that a new message can start. The block has a small two-state controller:

- **ST_SEED**: the engine holds the seed and refuses writes for one cycle. The controller enters it on the hardware reset and on every accepted clear.
- **ST_RUN**: writes are accepted.

The controller has three transitions:

- **seed_done**: from ST_SEED to ST_RUN, always after one cycle.
- **clear_req**: from ST_RUN back to ST_SEED, on an accepted control write with the clear bit set.
- **run_hold**: stay in ST_RUN for every other cycle.

Top module: `crc32w_engine`

## Requirements
- R1: While rst_n is low, the data register (read address 1) reads 0xFFFFFFFF and wr_ready is low. In the first cycle after rst_n rises, wr_ready is still low. It is high from the second cycle on.
- R2: An accepted write to address 0 with bit 0 set reloads the checksum with 0xFFFFFFFF. A read of address 1 in the following cycle returns 0xFFFFFFFF.
- R3: After an accepted clear, wr_ready is low for exactly one cycle and then high again. A data write presented in that cycle is not taken and leaves the checksum unchanged.
- R4: An accepted write to address 1 updates the checksum within one clock. The word is XORed into the checksum, then shifted out MSB first through 32 steps of polynomial 0x04C11DB7. There is no reflection and no final XOR.
- R5: A single word 0x00000000 written after a clear gives 0xC704DD7B.
- R6: The words 0x01020304, 0x05060708 and 0x090A0000 written in order after a clear give 0x07D41272.
- R7: The checksum is unchanged in any of these cases: wr_valid is low; a control write has bit 0 clear; or a write goes to address 2 or 3.
- R8: A read of address 1 returns the checksum including every write accepted up to the previous clock edge. Reads of addresses 0, 2 and 3 return zero.
- R9: Over long random word streams with random gaps and clears, the checksum matches a bit-serial model of R4 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_addr | input | 2 | Write register address (0 control, 1 data) |
| wr_data | input | 32 | Write data; bit 0 is the clear bit at address 0 |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Read data, combinational from rd_addr |

## Verification
A write taken at a rising edge shows up at rd_data straight after that edge. So the bench drives inputs on the falling edge and checks wr_ready against its model before the rising edge. It then compares rd_data on the next falling edge, one register stage after the stimulus. After a clear, the model expects wr_ready low for that single following cycle and counts a write offered then as not taken. The bench compares the model every clock, including during random gaps and clears, so a checksum that drifts by one cycle or takes a stalled write is caught in the cycle it happens.

// File: rtl/crc32w_pkg.sv
package crc32w_pkg;
    localparam int ADDR_W    = 2;
    localparam int WORD_W    = 32;
    localparam int CLEAR_BIT = 0;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd0;
    localparam logic [ADDR_W-1:0] DATA_ADDR = 2'd1;

    typedef enum logic {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } crc_state_t;
endpackage

// File: rtl/crc32w_step.sv
module crc32w_step #(
    parameter int W = 32,
    parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] word,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] stage [0:W];

    assign stage[0] = crc_in ^ word;

    for (genvar g = 0; g < W; g++) begin : g_shift
        assign stage[g+1] = stage[g][W-1] ? ({stage[g][W-2:0], 1'b0} ^ POLY)
                                          : {stage[g][W-2:0], 1'b0};
    end

    assign crc_out = stage[W];
endmodule

// File: rtl/crc32w_ctrl.sv
module crc32w_ctrl
    import crc32w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              clear_bit,
    output logic              wr_ready,
    output logic              take_data,
    output logic              take_clear,
    output crc_state_t        state
);
    crc_state_t state_d;
    logic       accept;

    assign accept = wr_valid && (state == ST_RUN);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_SEED: state_d = ST_RUN;
            ST_RUN:  if (accept && wr_addr == CTRL_ADDR && clear_bit) state_d = ST_SEED;
            default: state_d = ST_SEED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SEED;
        else        state <= state_d;
    end

    always_comb begin
        wr_ready   = 1'b0;
        take_data  = 1'b0;
        take_clear = 1'b0;
        unique case (state)
            ST_SEED: wr_ready = 1'b0;
            ST_RUN: begin
                wr_ready   = 1'b1;
                take_data  = wr_valid && (wr_addr == DATA_ADDR);
                take_clear = wr_valid && (wr_addr == CTRL_ADDR) && clear_bit;
            end
            default: wr_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/crc32w_engine.sv
module crc32w_engine
    import crc32w_pkg::*;
#(
    parameter logic [WORD_W-1:0] POLY = 32'h04C11DB7,
    parameter logic [WORD_W-1:0] SEED = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] crc_q;
    logic [WORD_W-1:0] crc_next;
    logic              take_data;
    logic              take_clear;
    crc_state_t        state;

    crc32w_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .clear_bit  (wr_data[CLEAR_BIT]),
        .wr_ready   (wr_ready),
        .take_data  (take_data),
        .take_clear (take_clear),
        .state      (state)
    );

    crc32w_step #(.W(WORD_W), .POLY(POLY)) u_step (
        .crc_in  (crc_q),
        .word    (wr_data),
        .crc_out (crc_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          crc_q <= SEED;
        else if (take_clear) crc_q <= SEED;
        else if (take_data)  crc_q <= crc_next;
    end

    assign rd_data = (rd_addr == DATA_ADDR) ? crc_q : '0;
endmodule

// File: rtl/crc32w_checks.sv
module crc32w_checks
    import crc32w_pkg::*;
#(
    parameter logic [WORD_W-1:0] SEED = 32'hFFFFFFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] crc_q
);
    logic clr_acc;
    logic any_change;
    assign clr_acc    = wr_valid && wr_ready && wr_addr == CTRL_ADDR && wr_data[CLEAR_BIT];
    assign any_change = wr_valid && wr_ready && (wr_addr == DATA_ADDR || clr_acc);

    assert_clear_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_acc |=> crc_q == SEED);

    assert_clear_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_acc |=> !wr_ready);

    assert_single_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> wr_ready);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !any_change |=> $stable(crc_q));
endmodule

bind crc32w_engine crc32w_checks #(.SEED(SEED)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .crc_q    (crc_q)
);

// File: tb/crc32w_engine_bench.sv
module crc32w_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd1;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] model = 32'hFFFFFFFF;
    bit exp_ready = 1'b0;

    always #4 clk = ~clk;

    crc32w_engine u_crc32w_engine (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [31:0] ref_step(logic [31:0] c, logic [31:0] d);
        logic fb;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c = c << 1;
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic cycle(bit v, logic [1:0] a, logic [31:0] d, logic [1:0] ra, string tag);
        bit acc;
        wr_valid = v; wr_addr = a; wr_data = d; rd_addr = ra;
        #1;
        check(wr_ready == exp_ready, {tag, " ready R3"}, {31'd0, wr_ready}, {31'd0, exp_ready});
        acc = v && exp_ready;
        @(negedge clk);
        exp_ready = 1'b1;
        if (acc && a == 2'd1) model = ref_step(model, d);
        if (acc && a == 2'd0 && d[0]) begin
            model = 32'hFFFFFFFF;
            exp_ready = 1'b0;
        end
        check(rd_data == ((ra == 2'd1) ? model : 32'd0), tag, rd_data,
              (ra == 2'd1) ? model : 32'd0);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check(rd_data == 32'hFFFFFFFF, "R1 seed in reset", rd_data, 32'hFFFFFFFF);
        check(wr_ready == 1'b0, "R1 ready in reset", {31'd0, wr_ready}, 32'd0);
        rst_n = 1'b1;
        exp_ready = 1'b0;
        cycle(1, 2'd1, 32'h12345678, 2'd1, "R1 first cycle write refused");
        cycle(1, 2'd1, 32'h00000000, 2'd1, "R5 zero word");
        check(rd_data == 32'hC704DD7B, "R5 known value", rd_data, 32'hC704DD7B);
        cycle(1, 2'd0, 32'h1, 2'd1, "R2 clear");
        check(rd_data == 32'hFFFFFFFF, "R2 seed after clear", rd_data, 32'hFFFFFFFF);
        cycle(1, 2'd1, 32'hDEADBEEF, 2'd1, "R3 write in stall cycle");
        check(rd_data == 32'hFFFFFFFF, "R3 stalled write no effect", rd_data, 32'hFFFFFFFF);
        cycle(1, 2'd1, 32'h01020304, 2'd1, "R6 word0");
        cycle(1, 2'd1, 32'h05060708, 2'd1, "R6 word1");
        cycle(0, 2'd1, 32'hFFFF0000, 2'd1, "R7 valid low");
        cycle(1, 2'd0, 32'hFFFFFFFE, 2'd1, "R7 ctrl without clear");
        cycle(1, 2'd2, 32'hAAAA5555, 2'd1, "R7 unused addr 2");
        cycle(1, 2'd3, 32'h5555AAAA, 2'd1, "R7 unused addr 3");
        cycle(1, 2'd1, 32'h090A0000, 2'd1, "R6 word2");
        check(rd_data == 32'h07D41272, "R6 known value", rd_data, 32'h07D41272);
        cycle(0, 2'd0, 32'h0, 2'd0, "R8 read ctrl");
        cycle(0, 2'd0, 32'h0, 2'd2, "R8 read addr 2");
        cycle(0, 2'd0, 32'h0, 2'd3, "R8 read addr 3");
        cycle(1, 2'd1, 32'h0BADF00D, 2'd1, "R4 back-to-back a");
        cycle(1, 2'd1, 32'hCAFEF00D, 2'd1, "R4 back-to-back b");
        for (int k = 0; k < 2000; k++) begin
            int r;
            logic [1:0] a;
            r = $urandom_range(0, 99);
            a = (r < 5) ? 2'd0 : (r < 8) ? 2'($urandom_range(2, 3)) : 2'd1;
            cycle(($urandom_range(0, 3) != 0), a, (a == 2'd0) ? 32'($urandom_range(0, 1)) : $urandom,
                  2'd1, "R9 random stream");
        end
        wr_valid = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule